// File: doc/BRIEF.md
# Wait-on-Reservation Stall Controller

This block sits in a processor core beside the instruction issue logic. It handles the two wait instructions that software uses in memory-polling loops. When one of them issues, the block recognises its encoding and holds the hart in a low-power stall. Software first registers a load-reserved reservation, then issues the wait. The stall lasts for as long as that reservation stays valid and no interrupt is pending. When the stall ends, the block reports completion with a single-cycle pulse.

The short-timeout form also ends itself after a fixed number of stall cycles, set by a parameter. The no-timeout form can stop by trapping. The trap happens when it runs outside machine mode under a wait-trap control bit and no wake arrives within a bounded number of cycles. Which exception it raises depends on the privilege mode, the virtualisation state and the two trap-control bits. The block does not track the reservation set itself; it receives only a valid flag. The pipeline is also outside the block.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: An issued word is a wait only if bits 6:0 are 0x73, bits 11:7, 14:12 and 19:15 are zero, and bits 31:20 are 0x00D (no-timeout form) or 0x01D (short-timeout form). Any other word presented with `issue_valid` produces no stall, no done and no exception.
- R2: A wait issued at clock edge t, while the reservation is valid, no interrupt is pending and no spurious wake is asserted, raises `stall` from edge t and keeps it high while none of the ending conditions below occurs.
- R3: If `resv_valid` is low during a stall cycle, `stall` falls and `done` pulses at the next edge.
- R4: Any set bit of `irq_pending` during a stall cycle ends the stall with a `done` pulse at the next edge. Interrupt enables play no part.
- R5: The short-timeout form, with no other wake, stays stalled for exactly `SHORT_CYCLES` cycles and then pulses `done`.
- R6: `spurious_wake` during a stall cycle ends the stall with a `done` pulse at the next edge.
- R7: If the reservation is invalid, an interrupt is pending or `spurious_wake` is high in the issue cycle, `done` pulses at the next edge and `stall` never rises.
- R8: The privilege mode and the trap bits are sampled at issue. For the no-timeout form with `tw`=1 and `priv` not 2'b11 (machine), `illegal_exc` pulses and `stall` falls after exactly `TRAP_CYCLES` stall cycles without a wake. No `done` is given in that case.
- R9: For the no-timeout form with `virt`=1, `priv` not machine, `tw`=0 and `vtw`=1, the same timing applies, but `virtual_exc` pulses instead of `illegal_exc`.
- R10: A no-timeout wait never traps if `tw`=0 and the virtual-trap condition is absent, or if it runs in machine mode. This covers user mode. Such a wait stalls until a wake.
- R11: The short-timeout form never raises either exception, whatever the trap bits.
- R12: If a wake occurs in the same cycle the trap bound expires, the wake wins: `done` pulses and no exception is raised.
- R13: After reset all four outputs are low. At most one of `done`, `illegal_exc` and `virtual_exc` is high in any cycle. `issue_valid` is ignored while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| resv_valid | input | 1 | Load-reserved reservation still held |
| irq_pending | input | NUM_IRQ | Pending interrupt lines, enabled or not |
| priv | input | 2 | Privilege mode: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Hart runs virtualised (VS/VU when not machine) |
| tw | input | 1 | Wait-trap control bit |
| vtw | input | 1 | Virtual wait-trap control bit |
| spurious_wake | input | 1 | Forces the current stall to complete |
| stall | output | 1 | Hart held in low-power wait |
| done | output | 1 | One-cycle completion pulse |
| illegal_exc | output | 1 | One-cycle illegal-instruction trap pulse |
| virtual_exc | output | 1 | One-cycle virtual-instruction trap pulse |

## Verification
Every result of this block is registered, so each outcome shows up one edge after the cycle whose inputs caused it. This holds for the rise of `stall`, an immediate `done`, a wake-driven `done` and a trap pulse. The timer outcomes add to that: a short-timeout `done` and a trap pulse come `SHORT_CYCLES` or `TRAP_CYCLES` edges after the issue edge. The bench drives inputs on the falling edge. A behavioural model then computes what the outputs must be after the coming rising edge, and the bench compares at the next falling edge. Each compare therefore lands exactly one edge after its stimulus, and a result one cycle early or late counts as a mismatch.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] F12_NTO    = 12'h00D;
  localparam logic [11:0] F12_STO    = 12'h01D;
  localparam logic [1:0]  PRIV_MACH  = 2'b11;

  typedef enum logic [1:0] {WK_NONE, WK_NTO, WK_STO} wait_kind_e;
  typedef enum logic [1:0] {TC_NONE, TC_ILL, TC_VIRT} trap_cls_e;
  typedef enum logic {ST_IDLE, ST_WAIT} stall_st_e;

  // Split the word into fields and match both wait encodings.
  function automatic wait_kind_e decode_wait(input logic [31:0] w);
    logic zero_regs;
    zero_regs = (w[11:7] == 5'd0) && (w[14:12] == 3'd0) && (w[19:15] == 5'd0);
    if (w[6:0] != OPC_SYSTEM || !zero_regs) return WK_NONE;
    if (w[31:20] == F12_NTO) return WK_NTO;
    if (w[31:20] == F12_STO) return WK_STO;
    return WK_NONE;
  endfunction

  // Which trap a bounded no-timeout wait would raise.
  function automatic trap_cls_e classify_trap(input wait_kind_e k, input logic [1:0] pm,
                                              input logic v, input logic t, input logic vt);
    if (k != WK_NTO || pm == PRIV_MACH) return TC_NONE;
    if (t) return TC_ILL;
    if (v && vt) return TC_VIRT;
    return TC_NONE;
  endfunction

  // A timer that started at zero hits its bound when it holds lim-1.
  function automatic logic bound_hit(input logic [31:0] cnt, input int unsigned lim);
    return cnt == 32'(lim - 1);
  endfunction
endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic [31:0] instr,
  output wait_kind_e  kind
);
  always_comb kind = decode_wait(instr);
endmodule

// File: rtl/wrs_trap_sel.sv
module wrs_trap_sel
  import wrs_pkg::*;
(
  input  wait_kind_e kind,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       tw,
  input  logic       vtw,
  output trap_cls_e  cls
);
  always_comb cls = classify_trap(kind, priv, virt, tw, vtw);
endmodule

// File: rtl/wrs_cycle_timer.sv
module wrs_cycle_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clear)               count <= '0;
    else if (run && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
  import wrs_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 200,
  parameter int unsigned TRAP_CYCLES  = 64,
  parameter int unsigned NUM_IRQ      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [31:0]        instr,
  input  logic               resv_valid,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic               tw,
  input  logic               vtw,
  input  logic               spurious_wake,
  output logic               stall,
  output logic               done,
  output logic               illegal_exc,
  output logic               virtual_exc
);
  localparam int unsigned MAX_BOUND = (SHORT_CYCLES > TRAP_CYCLES) ? SHORT_CYCLES : TRAP_CYCLES;
  localparam int unsigned CNT_W     = $clog2(MAX_BOUND + 1);

  stall_st_e        state_q;
  wait_kind_e       kind_in, kind_q;
  trap_cls_e        cls_in, cls_q;
  logic [CNT_W-1:0] cnt;
  logic             accept, wake_now, sto_hit, trap_hit;
  logic             wake_evt, trap_evt, kind_sto;
  logic             done_q, ill_q, virt_q;

  wrs_decode u_dec (.instr(instr), .kind(kind_in));

  wrs_trap_sel u_trap (
    .kind(kind_in), .priv(priv), .virt(virt), .tw(tw), .vtw(vtw), .cls(cls_in)
  );

  wrs_cycle_timer #(.WIDTH(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(state_q == ST_WAIT), .count(cnt)
  );

  // Named events used by the logic and by the bound checker.
  always_comb begin
    accept   = issue_valid && (state_q == ST_IDLE) && (kind_in != WK_NONE);
    wake_now = !resv_valid || (|irq_pending) || spurious_wake;
    kind_sto = (kind_q == WK_STO);
    sto_hit  = kind_sto && bound_hit(32'(cnt), SHORT_CYCLES);
    trap_hit = (kind_q == WK_NTO) && (cls_q != TC_NONE) && bound_hit(32'(cnt), TRAP_CYCLES);
    wake_evt = (state_q == ST_WAIT) && (wake_now || sto_hit);
    trap_evt = (state_q == ST_WAIT) && trap_hit && !wake_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= WK_NONE;
      cls_q   <= TC_NONE;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      virt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      virt_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (wake_now) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
              kind_q  <= kind_in;
              cls_q   <= cls_in;
            end
          end
        end
        ST_WAIT: begin
          if (wake_evt) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (trap_evt) begin
            ill_q   <= (cls_q == TC_ILL);
            virt_q  <= (cls_q == TC_VIRT);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stall       = (state_q == ST_WAIT);
  assign done        = done_q;
  assign illegal_exc = ill_q;
  assign virtual_exc = virt_q;
endmodule

// File: rtl/wrs_stall_chk.sv
module wrs_stall_chk #(
  parameter int unsigned NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               resv_valid,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic               spurious_wake,
  input logic               stall,
  input logic               done,
  input logic               illegal_exc,
  input logic               virtual_exc,
  input logic               wake_evt,
  input logic               trap_evt,
  input logic               kind_sto
);
  // R13
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal_exc, virtual_exc}));

  // R3
  resv_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !resv_valid) |=> (done && !stall));

  // R4
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (|irq_pending)) |=> (done && !stall));

  // R6
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && spurious_wake) |=> done);

  // R11
  sto_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && kind_sto) |=> !(illegal_exc || virtual_exc));

  // R12
  wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> !trap_evt);

  // R8
  trap_from_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_exc || virtual_exc) |-> $past(stall));
endmodule

bind wrs_stall_ctrl wrs_stall_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .resv_valid(resv_valid), .irq_pending(irq_pending),
  .spurious_wake(spurious_wake), .stall(stall), .done(done),
  .illegal_exc(illegal_exc), .virtual_exc(virtual_exc),
  .wake_evt(wake_evt), .trap_evt(trap_evt), .kind_sto(kind_sto)
);

// File: tb/wrs_stall_ctrl_tb.sv
module wrs_stall_ctrl_tb;
  localparam int SHORT = 200;
  localparam int TRAPB = 64;
  localparam int NIRQ  = 4;
  localparam logic [31:0] W_NTO = (32'h00D << 20) | 32'h73;
  localparam logic [31:0] W_STO = (32'h01D << 20) | 32'h73;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic resv_valid = 1'b1;
  logic [NIRQ-1:0] irq_pending = '0;
  logic [1:0] priv = 2'b00;
  logic virt = 1'b0, tw = 1'b0, vtw = 1'b0, spurious_wake = 1'b0;
  logic stall, done, illegal_exc, virtual_exc;

  always #10 clk = ~clk;

  wrs_stall_ctrl #(.SHORT_CYCLES(SHORT), .TRAP_CYCLES(TRAPB), .NUM_IRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .resv_valid(resv_valid), .irq_pending(irq_pending), .priv(priv), .virt(virt),
    .tw(tw), .vtw(vtw), .spurious_wake(spurious_wake), .stall(stall), .done(done),
    .illegal_exc(illegal_exc), .virtual_exc(virtual_exc)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R13";

  // Reference model state
  bit busy = 0;
  int elapsed = 0;
  bit is_short = 0;
  int trapk = 0;  // 0 none, 1 illegal, 2 virtual
  bit e_stall = 0, e_done = 0, e_ill = 0, e_vir = 0;

  function automatic int kind_of(input logic [31:0] w);
    if (w == W_NTO) return 1;
    if (w == W_STO) return 2;
    return 0;
  endfunction

  task automatic model();
    bit wake;
    e_done = 0; e_ill = 0; e_vir = 0;
    wake = !resv_valid || (irq_pending != 0) || spurious_wake;
    if (!busy) begin
      if (issue_valid && kind_of(instr) != 0) begin
        if (wake) e_done = 1;
        else begin
          busy = 1; elapsed = 0; is_short = (kind_of(instr) == 2); trapk = 0;
          if (!is_short && priv != 2'b11) begin
            if (tw) trapk = 1;
            else if (virt && vtw) trapk = 2;
          end
        end
      end
    end else begin
      if (wake || (is_short && elapsed + 1 == SHORT)) begin
        e_done = 1; busy = 0;
      end else if (trapk != 0 && elapsed + 1 == TRAPB) begin
        e_ill = (trapk == 1); e_vir = (trapk == 2); busy = 0;
      end else elapsed++;
    end
    e_stall = busy;
  endtask

  task automatic compare();
    checks++;
    if ({stall, done, illegal_exc, virtual_exc} !== {e_stall, e_done, e_ill, e_vir}) begin
      errors++;
      $display("FAIL %s t=%0t stall/done/ill/vir actual %b%b%b%b expected %b%b%b%b", tag, $time,
               stall, done, illegal_exc, virtual_exc, e_stall, e_done, e_ill, e_vir);
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic issue(input logic [31:0] w);
    issue_valid = 1; instr = w;
    step();
    issue_valid = 0; instr = '0;
  endtask

  task automatic settle();
    resv_valid = 1; irq_pending = '0; spurious_wake = 0;
    tw = 0; vtw = 0; virt = 0; priv = 2'b00;
    run(3);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R13"; compare();            // reset state, all low
    rst_n = 1;
    run(2);

    tag = "R1"; issue(W_NTO ^ 32'h0000_0080); run(2);   // rd nonzero
    issue(W_NTO ^ 32'h0000_1000); run(2);                // funct3 nonzero
    issue(32'h00200073); run(2);                         // other funct12
    issue(W_NTO ^ 32'h0000_8000); run(2);                // rs1 nonzero

    tag = "R3"; issue(W_NTO); run(10); resv_valid = 0; step(); settle();
    tag = "R4"; issue(W_NTO); run(5); irq_pending = 4'b0100; step(); settle();
    tag = "R6"; issue(W_STO); run(7); spurious_wake = 1; step(); settle();
    tag = "R5"; issue(W_STO); run(SHORT + 3); settle();
    tag = "R7"; resv_valid = 0; issue(W_NTO); settle();
    irq_pending = 4'b0001; issue(W_STO); settle();
    spurious_wake = 1; issue(W_NTO); settle();

    tag = "R8"; priv = 2'b00; tw = 1; issue(W_NTO); tw = 0; run(TRAPB + 3); settle();
    priv = 2'b01; virt = 1; tw = 1; vtw = 1; issue(W_NTO); run(TRAPB + 3); settle();
    tag = "R9"; priv = 2'b00; virt = 1; vtw = 1; issue(W_NTO); run(TRAPB + 3); settle();
    tag = "R10"; priv = 2'b11; tw = 1; vtw = 1; virt = 1; issue(W_NTO); run(TRAPB + 20);
    resv_valid = 0; step(); settle();
    priv = 2'b00; issue(W_NTO); run(TRAPB + 20); irq_pending = 4'b1000; step(); settle();
    priv = 2'b01; vtw = 1; virt = 0; issue(W_NTO); run(TRAPB + 5); resv_valid = 0; step(); settle();
    tag = "R11"; priv = 2'b00; tw = 1; vtw = 1; virt = 1; issue(W_STO); run(SHORT + 3); settle();
    tag = "R12"; priv = 2'b01; tw = 1; issue(W_NTO); run(TRAPB - 1); resv_valid = 0; step(); settle();
    tag = "R13"; issue(W_NTO); run(4); issue(W_STO); run(SHORT + 10); resv_valid = 0; step(); settle();
    tag = "R2"; issue(W_STO); run(50); spurious_wake = 1; step(); settle();

    finish_up();
  end
endmodule